// File: doc/BRIEF.md
# Quasi-Bidirectional Nibble Port with Expander Sequencer

This block owns four pins of a quasi-bidirectional I/O port. Each pin has three drive controls. A strong pull-down drives a zero. A strong pull-up drives a one, but only for the single clock after the pin rises. A weak pull-up then holds the one and also lets an outside device pull the line low. The block keeps a port latch that the core loads with a normal write, and it shows the latch on the pins when nothing else is using them.

The same four pins serve two other purposes.

- **Fetch override.** While the core fetches from external program memory, the pins carry the upper address nibble. When the fetch ends, the latched value returns on its own. Writes made during the fetch are kept and appear once the override drops.
- **Expander transaction.** The block runs a short sequence on a PROG strobe that talks to a 4-bit I/O expander. First it drives a command nibble, which the expander takes on the falling edge of PROG. Then it drives or samples a data nibble, which is exchanged on the rising edge. The transaction replaces the latch permanently. After a read, the latch holds all ones, so the lines sit weakly high. After a write, OR or AND, the latch holds the nibble that was sent.

Top module: `qbd_nibble_port`

## Requirements
- R1: After reset, every pin is weakly high (`pullup_on`=1111, `drv_low`=0000, `drv_high`=0000). `prog` is 1, and `exp_busy` and `exp_done` are 0.
- R2: In any cycle where a pin is driven, a 0 enables only `drv_low` and a 1 enables only `pullup_on`. No pin ever has both enabled.
- R3: `drv_high` of a bit is 1 for exactly one clock, in the first cycle that bit shows 1 after showing a driven 0. It is 0 at all other times.
- R4: `wr_req` loads `wr_data` into the latch when no expander transaction is in progress. The pins show the new value one clock later.
- R5: While `fetch_active` is 1 and no transaction is running, the pins show `fetch_addr` one clock later. The latch is not changed.
- R6: When `fetch_active` returns to 0, the pins show the latch again. This includes any value written while the override was active.
- R7: `exp_req` is accepted only when the block is idle and `fetch_active` is 0; otherwise it has no effect. Once accepted, `exp_busy` rises, and the pins carry the command nibble for two clocks. The command nibble is {op[1:0], sel[1:0]}, with op in bits 3:2 and the port select in bits 1:0. The op codes are 00 read, 01 write, 10 OR and 11 AND.
- R8: `prog` is 1 in the first command cycle. It is 0 for exactly two clocks (the second command cycle and the data cycle), then returns to 1 as the transaction ends. It is 0 at no other time.
- R9: For write, OR and AND, the data cycle drives `exp_wdata`. Afterwards the latch, and so the pins, hold `exp_wdata`.
- R10: For a read, all pins float in the data cycle (all three enables 0). `pin_in` is captured into `exp_rdata` as `prog` rises, and `exp_done` pulses for one clock. Afterwards the latch is 1111.
- R11: `wr_req` raised while `exp_busy` is 1 has no effect on the latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Load the port latch |
| wr_data | input | 4 | Value for the latch |
| fetch_active | input | 1 | External fetch in progress, override pins |
| fetch_addr | input | 4 | Address nibble shown during the fetch |
| exp_req | input | 1 | Start an expander transaction |
| exp_op | input | 2 | Expander operation code |
| exp_sel | input | 2 | Expander port select |
| exp_wdata | input | 4 | Data nibble for write, OR, AND |
| pin_in | input | 4 | Sensed pin levels |
| drv_low | output | 4 | Strong pull-down enable per pin |
| drv_high | output | 4 | Momentary strong pull-up enable per pin |
| pullup_on | output | 4 | Weak pull-up enable per pin |
| prog | output | 1 | Expander strobe, idle high |
| exp_busy | output | 1 | Transaction in progress |
| exp_done | output | 1 | One-clock pulse at transaction end |
| exp_rdata | output | 4 | Nibble captured by the last read |

## Verification
A latch write can arrive in the same cycle as an active fetch override. In that cycle the pins must keep showing the address while the latch takes the new value hidden. The bench provokes this with a vector that raises `wr_req` and `fetch_active` together. It judges the result twice: first that the pins do not change, then that the written value appears once the override drops. A second collision, a latch write during a read transaction, is judged by checking that the pins are 1111 after the transaction.

// File: rtl/qbd_pkg.sv
package qbd_pkg;
  localparam int OP_W = 2;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_CMD  = 2'd1,
    SQ_LOW  = 2'd2,
    SQ_DATA = 2'd3
  } seq_state_e;

  localparam logic [OP_W-1:0] OP_READ  = 2'b00;
  localparam logic [OP_W-1:0] OP_WRITE = 2'b01;
  localparam logic [OP_W-1:0] OP_OR    = 2'b10;
  localparam logic [OP_W-1:0] OP_AND   = 2'b11;
endpackage

// File: rtl/qbd_pin_cell.sv
module qbd_pin_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic val_d,
  input  logic flt_d,
  output logic drv_low,
  output logic drv_high,
  output logic pullup_on
);
  logic val_q, flt_q, hi_q;
  logic val_n, hi_n;

  // a floating pin is remembered as high, so a later 1 makes no pulse
  always_comb begin
    val_n = flt_d ? 1'b1 : val_d;
    hi_n  = !flt_d && val_d && !val_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= 1'b1;
      flt_q <= 1'b0;
      hi_q  <= 1'b0;
    end else begin
      val_q <= val_n;
      flt_q <= flt_d;
      hi_q  <= hi_n;
    end
  end

  assign drv_low   = !flt_q && !val_q;
  assign pullup_on = !flt_q && val_q;
  assign drv_high  = hi_q;

  assert_low_pullup_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_low && pullup_on));
  assert_pulse_one_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drv_high |=> !drv_high);
  assert_rise_gives_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pullup_on && $past(drv_low)) |-> drv_high);
endmodule

// File: rtl/qbd_exp_seq.sv
module qbd_exp_seq #(
  parameter int SEL_W = 2,
  localparam int W = qbd_pkg::OP_W + SEL_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req,
  input  logic                    fetch_active,
  input  logic [qbd_pkg::OP_W-1:0] op,
  input  logic [SEL_W-1:0]        sel,
  input  logic [W-1:0]            wdata,
  input  logic [W-1:0]            pin_in,
  output logic                    busy,
  output logic                    prog,
  output logic                    done,
  output logic                    done_read,
  output logic [W-1:0]            rdata,
  output logic                    finish,
  output logic [W-1:0]            fin_val,
  output logic                    own_d,
  output logic                    own_flt_d,
  output logic [W-1:0]            own_val_d
);
  import qbd_pkg::*;

  seq_state_e            state_q, state_d;
  logic [OP_W-1:0]       op_q, op_d;
  logic [SEL_W-1:0]      sel_q, sel_d;
  logic [W-1:0]          wd_q, wd_d;
  logic                  prog_q, prog_d;
  logic                  done_q, done_d;
  logic                  dread_q, dread_d;
  logic [W-1:0]          rdata_q;
  logic                  rdata_en;

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    sel_d   = sel_q;
    wd_d    = wd_q;
    unique case (state_q)
      SQ_IDLE: if (req && !fetch_active) begin
        state_d = SQ_CMD;
        op_d    = op;
        sel_d   = sel;
        wd_d    = wdata;
      end
      SQ_CMD:  state_d = SQ_LOW;
      SQ_LOW:  state_d = SQ_DATA;
      SQ_DATA: state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_comb begin
    finish    = (state_q == SQ_DATA);
    fin_val   = (op_q == OP_READ) ? {W{1'b1}} : wd_q;
    own_d     = (state_d != SQ_IDLE);
    own_flt_d = (state_d == SQ_DATA) && (op_d == OP_READ);
    own_val_d = (state_d == SQ_DATA) ? wd_d : {op_d, sel_d};
    prog_d    = !((state_d == SQ_LOW) || (state_d == SQ_DATA));
    done_d    = finish;
    dread_d   = finish && (op_q == OP_READ);
    rdata_en  = dread_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      op_q    <= OP_READ;
      sel_q   <= '0;
      wd_q    <= '0;
      prog_q  <= 1'b1;
      done_q  <= 1'b0;
      dread_q <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      sel_q   <= sel_d;
      wd_q    <= wd_d;
      prog_q  <= prog_d;
      done_q  <= done_d;
      dread_q <= dread_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (rdata_en) rdata_q <= pin_in;
  end

  assign busy      = (state_q != SQ_IDLE);
  assign prog      = prog_q;
  assign done      = done_q;
  assign done_read = dread_q;
  assign rdata     = rdata_q;

  assert_prog_low_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !prog |-> busy);
  assert_prog_low_two_clocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog) |=> (!prog ##1 prog));
  assert_done_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

// File: rtl/qbd_nibble_port.sv
module qbd_nibble_port #(
  parameter int SEL_W = 2,
  localparam int W = qbd_pkg::OP_W + SEL_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_req,
  input  logic [W-1:0]             wr_data,
  input  logic                     fetch_active,
  input  logic [W-1:0]             fetch_addr,
  input  logic                     exp_req,
  input  logic [qbd_pkg::OP_W-1:0] exp_op,
  input  logic [SEL_W-1:0]         exp_sel,
  input  logic [W-1:0]             exp_wdata,
  input  logic [W-1:0]             pin_in,
  output logic [W-1:0]             drv_low,
  output logic [W-1:0]             drv_high,
  output logic [W-1:0]             pullup_on,
  output logic                     prog,
  output logic                     exp_busy,
  output logic                     exp_done,
  output logic [W-1:0]             exp_rdata
);
  logic [W-1:0] latch_q, latch_d;
  logic [W-1:0] pin_val_d;
  logic         pin_flt_d;
  logic         finish, own_d, own_flt_d, done_read;
  logic [W-1:0] fin_val, own_val_d;
  logic         latch_en;

  qbd_exp_seq #(.SEL_W(SEL_W)) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (exp_req),
    .fetch_active(fetch_active),
    .op          (exp_op),
    .sel         (exp_sel),
    .wdata       (exp_wdata),
    .pin_in      (pin_in),
    .busy        (exp_busy),
    .prog        (prog),
    .done        (exp_done),
    .done_read   (done_read),
    .rdata       (exp_rdata),
    .finish      (finish),
    .fin_val     (fin_val),
    .own_d       (own_d),
    .own_flt_d   (own_flt_d),
    .own_val_d   (own_val_d)
  );

  // the expander result wins; core writes are held off while it runs
  always_comb begin
    latch_en = finish || (wr_req && !exp_busy);
    latch_d  = finish ? fin_val : wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '1;
    else if (latch_en) latch_q <= latch_d;
  end

  always_comb begin
    if (own_d)             pin_val_d = own_val_d;
    else if (fetch_active) pin_val_d = fetch_addr;
    else                   pin_val_d = latch_en ? latch_d : latch_q;
    pin_flt_d = own_d && own_flt_d;
  end

  for (genvar b = 0; b < W; b++) begin : g_pin
    qbd_pin_cell i_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .val_d    (pin_val_d[b]),
      .flt_d    (pin_flt_d),
      .drv_low  (drv_low[b]),
      .drv_high (drv_high[b]),
      .pullup_on(pullup_on[b])
    );
  end

  assert_fetch_shows_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fetch_active) && !$past(exp_busy)) |-> (pullup_on == $past(fetch_addr)));
  assert_read_leaves_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_done && done_read && !$past(fetch_active)) |-> (pullup_on == {W{1'b1}}));
  assert_write_ignored_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_busy && !finish) |=> $stable(latch_q));
endmodule

// File: tb/test_qbd_nibble_port.sv
module test_qbd_nibble_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_req, fetch_active, exp_req;
  logic [3:0] wr_data, fetch_addr, exp_wdata, pin_in;
  logic [1:0] exp_op, exp_sel;
  logic [3:0] drv_low, drv_high, pullup_on, exp_rdata;
  logic       prog, exp_busy, exp_done;

  int n_tests = 0;
  int n_fail  = 0;
  logic [3:0] prev_shown;

  always #5 clk = ~clk;

  qbd_nibble_port i_qbd_nibble_port (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_data),
    .fetch_active(fetch_active), .fetch_addr(fetch_addr), .exp_req(exp_req),
    .exp_op(exp_op), .exp_sel(exp_sel), .exp_wdata(exp_wdata), .pin_in(pin_in),
    .drv_low(drv_low), .drv_high(drv_high), .pullup_on(pullup_on), .prog(prog),
    .exp_busy(exp_busy), .exp_done(exp_done), .exp_rdata(exp_rdata)
  );

  // {wr_req, wr_data, fetch_active, fetch_addr, expected shown nibble}
  localparam int NV = 10;
  localparam logic [13:0] VEC [0:NV-1] = '{
    {1'b1, 4'h5, 1'b0, 4'h0, 4'h5},
    {1'b1, 4'hA, 1'b0, 4'h0, 4'hA},
    {1'b0, 4'h0, 1'b1, 4'h3, 4'h3},
    {1'b1, 4'hC, 1'b1, 4'h3, 4'h3},
    {1'b0, 4'h0, 1'b0, 4'h0, 4'hC},
    {1'b0, 4'h0, 1'b1, 4'h0, 4'h0},
    {1'b0, 4'h0, 1'b0, 4'h0, 4'hC},
    {1'b1, 4'h0, 1'b0, 4'h0, 4'h0},
    {1'b1, 4'hF, 1'b0, 4'h0, 4'hF},
    {1'b0, 4'h0, 1'b0, 4'h0, 4'hF}
  };

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_pins(input string tag, input logic [3:0] shown, input logic flt);
    logic [3:0] e_low, e_pu, e_hi;
    e_low = flt ? 4'h0 : ~shown;
    e_pu  = flt ? 4'h0 : shown;
    e_hi  = flt ? 4'h0 : (shown & ~prev_shown);
    chk({tag, " R2 drv_low"}, drv_low, e_low);
    chk({tag, " R2 pullup_on"}, pullup_on, e_pu);
    chk({tag, " R3 drv_high"}, drv_high, e_hi);
    prev_shown = flt ? 4'hF : shown;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic exp_run(input logic [1:0] op, input logic [1:0] sel, input logic [3:0] wd,
                         input logic [3:0] pv, input logic hit_wr);
    logic [3:0] after;
    after = (op == 2'b00) ? 4'hF : wd;
    exp_req = 1'b1; exp_op = op; exp_sel = sel; exp_wdata = wd; pin_in = pv;
    step();
    exp_req = 1'b0;
    chk("R7 busy on accept", {3'b0, exp_busy}, 4'h1);
    chk("R8 prog high first cmd cycle", {3'b0, prog}, 4'h1);
    chk_pins("R7 cmd nibble", {op, sel}, 1'b0);
    step();
    chk("R8 prog low cmd cycle", {3'b0, prog}, 4'h0);
    chk_pins("R7 cmd nibble held", {op, sel}, 1'b0);
    if (hit_wr) begin wr_req = 1'b1; wr_data = 4'h0; end
    step();
    wr_req = 1'b0;
    chk("R8 prog low data cycle", {3'b0, prog}, 4'h0);
    if (op == 2'b00) chk_pins("R10 float in data", 4'h0, 1'b1);
    else             chk_pins("R9 data driven", wd, 1'b0);
    step();
    chk("R8 prog back high", {3'b0, prog}, 4'h1);
    chk("R10 done pulse", {3'b0, exp_done}, 4'h1);
    chk("R7 busy cleared", {3'b0, exp_busy}, 4'h0);
    if (op == 2'b00) chk("R10 read data", exp_rdata, pv);
    chk_pins((op == 2'b00) ? "R10 latch ones" : "R9 latch holds", after, 1'b0);
    step();
    chk("R10 done one clock", {3'b0, exp_done}, 4'h0);
    chk_pins(hit_wr ? "R11 write ignored" : "R9 latch stays", after, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; wr_req = 1'b0; wr_data = '0; fetch_active = 1'b0; fetch_addr = '0;
    exp_req = 1'b0; exp_op = '0; exp_sel = '0; exp_wdata = '0; pin_in = '0;
    prev_shown = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk_pins("R1 reset pins", 4'hF, 1'b0);
    chk("R1 prog idle", {3'b0, prog}, 4'h1);
    chk("R1 busy idle", {3'b0, exp_busy}, 4'h0);
    chk("R1 done idle", {3'b0, exp_done}, 4'h0);

    // vector table: latch writes and fetch overrides (R4, R5, R6)
    for (int i = 0; i < NV; i++) begin
      logic was_fetch;
      was_fetch = fetch_active;
      wr_req = VEC[i][13]; wr_data = VEC[i][12:9];
      fetch_active = VEC[i][8]; fetch_addr = VEC[i][7:4];
      step();
      if (VEC[i][8])      chk_pins("R5 fetch override", VEC[i][3:0], 1'b0);
      else if (was_fetch) chk_pins("R6 latch restored", VEC[i][3:0], 1'b0);
      else                chk_pins("R4 latch write", VEC[i][3:0], 1'b0);
    end
    wr_req = 1'b0; fetch_active = 1'b0;

    // R7 request ignored during fetch
    fetch_active = 1'b1; fetch_addr = 4'h5; exp_req = 1'b1;
    step();
    chk("R7 no accept in fetch", {3'b0, exp_busy}, 4'h0);
    chk("R8 prog idle in fetch", {3'b0, prog}, 4'h1);
    chk_pins("R5 fetch addr", 4'h5, 1'b0);
    fetch_active = 1'b0; exp_req = 1'b0;
    step();
    chk("R7 still idle", {3'b0, exp_busy}, 4'h0);
    chk_pins("R6 restore after fetch", 4'hF, 1'b0);

    exp_run(2'b01, 2'b10, 4'h6, 4'h0, 1'b0);  // write
    exp_run(2'b00, 2'b01, 4'h3, 4'h9, 1'b1);  // read, with blocked core write
    exp_run(2'b10, 2'b11, 4'h3, 4'h0, 1'b0);  // OR
    exp_run(2'b11, 2'b00, 4'h8, 4'h0, 1'b0);  // AND

    // fetch override after an expander write restores the written nibble
    fetch_active = 1'b1; fetch_addr = 4'h7;
    step();
    chk_pins("R5 fetch after expander", 4'h7, 1'b0);
    fetch_active = 1'b0;
    step();
    chk_pins("R6 restore expander nibble", 4'h8, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule